// File: doc/BRIEF.md
# Two-Pass Modulo 2^W-1 Adder

This block adds two W-bit unsigned operands modulo 2^W-1 using a single W-bit adder that has a carry input and a carry output. The adder is shared over two clock cycles, so each operand pair occupies a two-cycle slot. In the default probe mode, the first pass adds with carry-in 1. A carry-out from that pass means the operand sum has reached 2^W-1, and the low W bits are already the reduced answer. If there is no carry-out, the second pass adds again with carry-in 0, and that sum is the answer. This handles an operand sum of exactly 2^W-1 and reduces it to zero, which a plain end-around carry cannot do.

A parameter selects an alternate end-around-carry mode. That mode runs the plain sum first. A carry-out from the plain sum makes the second pass add with carry-in 1. In this mode an operand sum of exactly 2^W-1 stays all ones.

A consumer holds the operands for a full slot and reads the result while the one-cycle `sum_valid` pulse is high. Slots run back to back. The cycle in which `sum_valid` is high is also the first cycle of the next slot.

Top module: `modadd_two_pass`

## Requirements
- R1: While `rst_n` is 0, `sum_valid` and `sum_out` are 0. After `rst_n` rises, `sum_valid` first goes 1 on the fourth rising clock edge: two edges of reset synchronization, then one two-cycle slot.
- R2: Slots repeat every two clock cycles. `sum_valid` is high for exactly one cycle in each slot, never in two consecutive cycles. The operands used are the ones held during the two cycles that end with the rising edge that raises `sum_valid`.
- R3: With MODE=0, let S be the full (W+1)-bit sum `opnd_a + opnd_b` and M = 2^W-1. `sum_out` is S-M when S >= M, and S otherwise.
- R4: With MODE=0, an operand sum of exactly M gives `sum_out` = 0.
- R5: With MODE=0, two all-ones operands give an all-ones `sum_out`, because S = 2M and S-M = M.
- R6: With MODE=0, a sum of M-1 is returned unchanged, and a sum of exactly 2^W gives 1.
- R7: With MODE=1, `sum_out` is the low W bits of S when S < 2^W, and S-2^W+1 otherwise. A sum of exactly M therefore gives all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| opnd_a | input | W | First operand, held for the whole slot |
| opnd_b | input | W | Second operand, held for the whole slot |
| sum_out | output | W | Reduced sum; meaningful while `sum_valid` is 1 |
| sum_valid | output | 1 | One-cycle pulse marking a finished slot |

## Verification
The assertions check the following on every cycle:
- the carry-in phase alternates;
- `sum_valid` never lasts two cycles and only appears in a first-pass cycle;
- each result matches the reduction rule of the selected mode, applied to the operands of the slot that just ended;
- an operand sum of exactly M gives zero in probe mode.

Only the bench scenarios can show the things that depend on a chosen stimulus:
- the exact number of edges from reset release to the first result;
- the named boundary sums M-1, M, 2^W and 2M;
- that both modes disagree only where they should.

// File: rtl/modadd_pkg.sv
package modadd_pkg;

  typedef enum logic {
    PASS_FIRST  = 1'b0,
    PASS_SECOND = 1'b1
  } pass_e;

  localparam int MODE_PROBE = 0;
  localparam int MODE_EAC   = 1;

endpackage

// File: rtl/modadd_rst_sync.sv
module modadd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/modadd_carry_adder.sv
module modadd_carry_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] add_x,
  input  logic [W-1:0] add_y,
  input  logic         carry_in,
  output logic [W-1:0] add_sum,
  output logic         carry_out
);

  localparam int FULL_W = W + 1;

  logic [FULL_W-1:0] wide_sum;

  always_comb begin
    wide_sum  = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, carry_in};
    add_sum   = wide_sum[W-1:0];
    carry_out = wide_sum[W];
  end

endmodule

// File: rtl/modadd_pass_ctrl.sv
module modadd_pass_ctrl
  import modadd_pkg::*;
#(
  parameter int MODE = MODE_PROBE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic carry_out,
  output logic carry_in,
  output logic take_sum,
  output logic pass_second,
  output logic slot_done
);

  pass_e pass_q, pass_d;
  logic  cout_q, cout_d;
  logic  done_q, done_d;
  logic  in_first;

  assign in_first    = (pass_q == PASS_FIRST);
  assign pass_second = (pass_q == PASS_SECOND);

  // The mode decides which carry-in the first pass uses and which carry
  // outcome ends the slot early.
  generate
    if (MODE == MODE_EAC) begin : g_eac
      assign carry_in = pass_second;
      assign take_sum = (in_first & ~carry_out) | (pass_second & cout_q);
    end else begin : g_probe
      assign carry_in = in_first;
      assign take_sum = (in_first & carry_out) | (pass_second & ~cout_q);
    end
  endgenerate

  always_comb begin
    pass_d = in_first ? PASS_SECOND : PASS_FIRST;
    cout_d = cout_q;
    if (in_first) begin
      cout_d = carry_out;
    end
    done_d = pass_second;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= PASS_FIRST;
      cout_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pass_q <= pass_d;
      cout_q <= cout_d;
      done_q <= done_d;
    end
  end

  assign slot_done = done_q;

endmodule

// File: rtl/modadd_result_reg.sv
module modadd_result_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] held_val
);

  logic [W-1:0] val_q, val_d;

  always_comb begin
    val_d = val_q;
    if (load_en) begin
      val_d = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else begin
      val_q <= val_d;
    end
  end

  assign held_val = val_q;

endmodule

// File: rtl/modadd_two_pass.sv
module modadd_two_pass
  import modadd_pkg::*;
#(
  parameter int W    = 32,
  parameter int MODE = MODE_PROBE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] sum_out,
  output logic         sum_valid
);

  logic         rst_sync_n;
  logic         carry_in;
  logic         carry_out;
  logic         take_sum;
  logic         pass_second;
  logic [W-1:0] pass_sum;

  modadd_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  modadd_carry_adder #(.W(W)) u_adder (
    .add_x     (opnd_a),
    .add_y     (opnd_b),
    .carry_in  (carry_in),
    .add_sum   (pass_sum),
    .carry_out (carry_out)
  );

  modadd_pass_ctrl #(.MODE(MODE)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .carry_out   (carry_out),
    .carry_in    (carry_in),
    .take_sum    (take_sum),
    .pass_second (pass_second),
    .slot_done   (sum_valid)
  );

  modadd_result_reg #(.W(W)) u_result (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (take_sum),
    .load_val (pass_sum),
    .held_val (sum_out)
  );

endmodule

// File: rtl/modadd_two_pass_chk.sv
module modadd_two_pass_chk #(
  parameter int W    = 32,
  parameter int MODE = 0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rst_sync_n,
  input logic         pass_second,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] sum_out,
  input logic         sum_valid
);

  localparam logic [W:0] MOD_M = {1'b0, {W{1'b1}}};

  function automatic logic [W-1:0] model_probe(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s;
    logic [W:0] r;
    s = {1'b0, x} + {1'b0, y};
    r = (s >= MOD_M) ? (s - MOD_M) : s;
    return r[W-1:0];
  endfunction

  function automatic logic [W-1:0] model_eac(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s;
    s = {1'b0, x} + {1'b0, y};
    return s[W] ? (s[W-1:0] + {{(W-1){1'b0}}, 1'b1}) : s[W-1:0];
  endfunction

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (!sum_valid && sum_out == '0));

  assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sum_valid |=> !sum_valid);

  assert_valid_first_pass_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sum_valid |-> !pass_second);

  assert_pass_to_second_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pass_second |=> pass_second);

  assert_pass_to_first_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pass_second |=> !pass_second);

  generate
    if (MODE == 1) begin : g_eac_chk
      assert_eac_result_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
        sum_valid |-> sum_out == model_eac($past(opnd_a), $past(opnd_b)));
    end else begin : g_probe_chk
      assert_probe_result_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
        sum_valid |-> sum_out == model_probe($past(opnd_a), $past(opnd_b)));
      assert_exact_mod_zero_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (sum_valid && ({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)}) == MOD_M)
        |-> sum_out == '0);
    end
  endgenerate

endmodule

bind modadd_two_pass modadd_two_pass_chk #(.W(W), .MODE(MODE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_sync_n  (rst_sync_n),
  .pass_second (pass_second),
  .opnd_a      (opnd_a),
  .opnd_b      (opnd_b),
  .sum_out     (sum_out),
  .sum_valid   (sum_valid)
);

// File: tb/modadd_two_pass_test.sv
`timescale 1ns/1ps
module modadd_two_pass_test;

  localparam int W = 32;
  localparam real HALF = 2.5;
  localparam logic [W:0] MOD_M = {1'b0, {W{1'b1}}};

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a_in;
  logic [W-1:0] b_in;
  logic [W-1:0] probe_sum;
  logic         probe_vld;
  logic [W-1:0] eac_sum;
  logic         eac_vld;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  modadd_two_pass #(.W(W), .MODE(0)) uut (
    .clk(clk), .rst_n(rst_n), .opnd_a(a_in), .opnd_b(b_in),
    .sum_out(probe_sum), .sum_valid(probe_vld)
  );

  modadd_two_pass #(.W(W), .MODE(1)) uut_eac (
    .clk(clk), .rst_n(rst_n), .opnd_a(a_in), .opnd_b(b_in),
    .sum_out(eac_sum), .sum_valid(eac_vld)
  );

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;

  function automatic logic [W-1:0] exp_probe(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s;
    logic [W:0] r;
    s = {1'b0, x} + {1'b0, y};
    r = (s >= MOD_M) ? (s - MOD_M) : s;
    return r[W-1:0];
  endfunction

  function automatic logic [W-1:0] exp_eac(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s;
    logic [W:0] r;
    s = {1'b0, x} + {1'b0, y};
    r = s[W] ? (s - {1'b1, {W{1'b0}}} + 1) : s;
    return r[W-1:0];
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R1: idle outputs in reset, then first result on the fourth edge.
  task automatic test_reset();
    int edges;
    rst_n = 1'b0;
    a_in  = '0;
    b_in  = '0;
    repeat (3) @(negedge clk);
    check("R1 probe valid in reset", W'(probe_vld), '0);
    check("R1 probe sum in reset", probe_sum, '0);
    check("R1 eac valid in reset", W'(eac_vld), '0);
    rst_n = 1'b1;
    edges = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      edges++;
      if (probe_vld) break;
    end
    check("R1 edges to first valid", W'(edges), W'(4));
    check("R1 eac valid aligned", W'(eac_vld), W'(1));
    check("R1 first result", probe_sum, '0);
  endtask

  // R2 timing plus result checks; called at a negedge where valid is high.
  task automatic run_slot(input string tag, input logic [W-1:0] x, input logic [W-1:0] y);
    a_in = x;
    b_in = y;
    @(negedge clk);
    check({"R2 mid-slot valid low ", tag}, W'(probe_vld | eac_vld), '0);
    @(negedge clk);
    check({"R2 probe valid ", tag}, W'(probe_vld), W'(1));
    check({"R2 eac valid ", tag}, W'(eac_vld), W'(1));
    check({tag, " probe"}, probe_sum, exp_probe(x, y));
    check({"R7 ", tag, " eac"}, eac_sum, exp_eac(x, y));
  endtask

  task automatic test_boundaries();
    run_slot("R6 sum M-1", 32'hFFFF_FFFE, 32'h0000_0000);
    check("R6 sum M-1 literal", probe_sum, 32'hFFFF_FFFE);
    run_slot("R4 sum M split", 32'h8000_0000, 32'h7FFF_FFFF);
    check("R4 sum M literal zero", probe_sum, 32'h0000_0000);
    check("R7 sum M stays ones", eac_sum, 32'hFFFF_FFFF);
    run_slot("R4 ones plus zero", 32'hFFFF_FFFF, 32'h0000_0000);
    check("R4 ones plus zero literal", probe_sum, 32'h0000_0000);
    run_slot("R6 sum 2^W", 32'h8000_0000, 32'h8000_0000);
    check("R6 sum 2^W literal", probe_sum, 32'h0000_0001);
    run_slot("R6 ones plus one", 32'hFFFF_FFFF, 32'h0000_0001);
    check("R6 ones plus one literal", probe_sum, 32'h0000_0001);
    run_slot("R5 all ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R5 all ones literal", probe_sum, 32'hFFFF_FFFF);
    run_slot("R3 zeros", 32'h0000_0000, 32'h0000_0000);
  endtask

  task automatic test_small_values();
    run_slot("R3 small", 32'h0000_1234, 32'h0000_0042);
    run_slot("R3 just over", 32'hF000_0000, 32'h1000_0005);
    run_slot("R3 just under", 32'hF000_0000, 32'h0FFF_FFFD);
  endtask

  task automatic test_random();
    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] x;
      logic [W-1:0] y;
      x = $urandom();
      y = $urandom();
      run_slot("R3 random", x, y);
    end
  endtask

  initial begin
    test_reset();
    test_boundaries();
    test_small_values();
    test_random();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule